// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sorts up to 256 interrupt vectors for a single processor. Sources post requests as one-cycle pulses that carry a vector number and a trigger type. The controller keeps three 256-bit state vectors: pending requests, vectors in service, and the trigger type of each pending vector. It also keeps a task priority value and a spurious/enable register. A larger vector number means higher urgency. Vectors fall into 16-vector priority classes, and the class is the upper four bits of the vector.

The controller derives a processor priority from the task priority and the class of the highest vector in service. It raises the interrupt line only when the best pending class is more urgent than that priority. The processor pulses an acknowledge to receive a vector. The controller answers on the following cycle with the granted vector, the spurious vector, or a no-vector flag. An end-of-interrupt pulse retires the most urgent vector in service.

Top module: `vprio_ctrl`

## Requirements
- R1: A request pulse sets the pending bit of its vector. It records level trigger when `req_level` is 1 and edge trigger when it is 0. The trigger type of a granted vector is reported on `ack_rsp_level`.
- R2: `ppr` equals the task priority when the task priority's bits 7:4 are at least the class (bits 7:4) of the highest in-service vector, or when nothing is in service. Otherwise `ppr` equals that class with the low four bits zero.
- R3: `irq` is high only when the enable bit is set and a vector is pending. In addition, either `ppr` is zero or the class of the highest pending vector is greater than bits 7:4 of `ppr`.
- R4: An acknowledge is blocked when the task priority is nonzero and the highest pending vector is at or below it. A blocked acknowledge returns bits 7:0 of the spurious register with `ack_rsp_none` low, and leaves pending and in-service state unchanged.
- R5: An unblocked acknowledge answers one cycle later with the highest pending vector. That vector's pending bit is cleared and its in-service bit is set. Every acknowledge produces exactly one `ack_rsp_valid` pulse, one cycle later.
- R6: End-of-interrupt clears only the highest set in-service bit. With nothing in service it changes nothing.
- R7: An acknowledge with nothing pending returns `ack_rsp_none` high and changes no state.
- R8: The spurious register keeps only bits 8:0 of a write, and `spur_rd` reads it back. It resets to 0x0FF. The task priority resets to 0.
- R9: While the enable bit (bit 8 of the spurious register) is clear, `irq` stays low and every acknowledge returns `ack_rsp_none` high without changing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request pulse |
| req_vector | input | 8 | Vector of the request |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Acknowledge pulse from the processor |
| eoi_wr | input | 1 | End-of-interrupt write pulse |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| svr_wr | input | 1 | Spurious/enable register write strobe |
| svr_wdata | input | 16 | Spurious/enable write value (bits 15:9 dropped) |
| irq | output | 1 | Interrupt line to the processor |
| ppr | output | 8 | Processor priority |
| spur_rd | output | 9 | Spurious/enable register readback |
| ack_rsp_valid | output | 1 | Acknowledge answer strobe |
| ack_rsp_none | output | 1 | Acknowledge found no vector to give |
| ack_rsp_vector | output | 8 | Granted or spurious vector |
| ack_rsp_level | output | 1 | Trigger type of the granted vector |

## Verification
Every one of the 256 vectors goes alone through the request, acknowledge and end-of-interrupt path, with the trigger type alternating between vectors. This separates encoder slicing faults, trigger-bit faults and priority-class derivation faults per vector. A full 16-by-16 matrix of task-priority class against pending class follows, with equal low nibbles. It separates the strict class comparison for the line from the inclusive vector comparison for spurious blocking, including the equal-class diagonal. The bench then runs a long pseudo-random mix of requests, acknowledges, end-of-interrupts and register writes against an arithmetic model. That mix exercises nested in-service vectors, multiple pending vectors and enable toggling. Dedicated steps cover the disabled state, acknowledge with nothing pending, end-of-interrupt with nothing in service, and masking of the spurious register write.

// File: rtl/vprio_pkg.sv
package vprio_pkg;
  // vectors per priority class, as a bit count
  localparam int unsigned GRP_BITS = 4;
  localparam int unsigned GRP_SIZE = 1 << GRP_BITS;
endpackage

// File: rtl/vprio_penc.sv
// Highest-set-bit search in two levels: per-class encoders, then class select.
module vprio_penc #(
  parameter int unsigned N = 256
) (
  input  logic [N-1:0]         vec,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned GB = vprio_pkg::GRP_BITS;
  localparam int unsigned GS = vprio_pkg::GRP_SIZE;
  localparam int unsigned NG = N / GS;
  localparam int unsigned CW = IW - GB;

  logic [NG-1:0]    grp_any;
  logic [NG*GB-1:0] grp_idx;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GB-1:0] loc_idx;
    always_comb begin
      loc_idx = '0;
      for (int b = 0; b < GS; b++) begin
        if (vec[g*GS+b]) loc_idx = GB'(b);
      end
    end
    assign grp_any[g]            = |vec[g*GS +: GS];
    assign grp_idx[g*GB +: GB]   = loc_idx;
  end

  always_comb begin
    idx = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp_any[g]) idx = {CW'(g), grp_idx[g*GB +: GB]};
    end
  end

  assign any = |grp_any;
endmodule

// File: rtl/vprio_gate.sv
// Processor priority, line gating and acknowledge blocking.
module vprio_gate #(
  parameter int unsigned VW = 8
) (
  input  logic          en,
  input  logic [VW-1:0] tpr,
  input  logic          irr_any,
  input  logic [VW-1:0] irr_idx,
  input  logic          isr_any,
  input  logic [VW-1:0] isr_idx,
  output logic [VW-1:0] ppr,
  output logic          irq,
  output logic          ack_block
);
  localparam int unsigned GB = vprio_pkg::GRP_BITS;
  localparam int unsigned CW = VW - GB;

  logic [CW-1:0] isr_cls;
  logic [CW-1:0] tpr_cls;
  logic [CW-1:0] irr_cls;

  assign isr_cls = isr_any ? isr_idx[VW-1 -: CW] : '0;
  assign tpr_cls = tpr[VW-1 -: CW];
  assign irr_cls = irr_idx[VW-1 -: CW];

  assign ppr       = (tpr_cls >= isr_cls) ? tpr : {isr_cls, {GB{1'b0}}};
  assign irq       = en && irr_any && ((ppr == '0) || (irr_cls > ppr[VW-1 -: CW]));
  assign ack_block = (tpr != '0) && (irr_idx <= tpr);
endmodule

// File: rtl/vprio_ctrl.sv
module vprio_ctrl #(
  parameter int unsigned NVEC = 256,
  parameter int unsigned WD   = 16,
  localparam int unsigned VW  = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vector,
  input  logic          req_level,
  input  logic          ack_req,
  input  logic          eoi_wr,
  input  logic          tpr_wr,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          svr_wr,
  input  logic [WD-1:0] svr_wdata,
  output logic          irq,
  output logic [VW-1:0] ppr,
  output logic [VW:0]   spur_rd,
  output logic          ack_rsp_valid,
  output logic          ack_rsp_none,
  output logic [VW-1:0] ack_rsp_vector,
  output logic          ack_rsp_level
);
  // reset synchronizer: asserts at once, releases on the second edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [NVEC-1:0] irr_q, irr_n, isr_q, isr_n, tmr_q, tmr_n;
  logic [VW-1:0]   tpr_q, tpr_n;
  logic [VW:0]     svr_q, svr_n;
  logic            rsp_v_n, rsp_none_n, rsp_lvl_n;
  logic [VW-1:0]   rsp_vec_n;
  logic            irr_any, isr_any, ack_block, en;
  logic [VW-1:0]   irr_idx, isr_idx;

  assign en = svr_q[VW];

  vprio_penc #(.N(NVEC)) u_irr_enc (.vec(irr_q), .any(irr_any), .idx(irr_idx));
  vprio_penc #(.N(NVEC)) u_isr_enc (.vec(isr_q), .any(isr_any), .idx(isr_idx));

  vprio_gate #(.VW(VW)) u_gate (
    .en(en), .tpr(tpr_q),
    .irr_any(irr_any), .irr_idx(irr_idx),
    .isr_any(isr_any), .isr_idx(isr_idx),
    .ppr(ppr), .irq(irq), .ack_block(ack_block)
  );

  // next state; a new request wins over a same-cycle grant of that vector
  always_comb begin
    irr_n      = irr_q;
    isr_n      = isr_q;
    tmr_n      = tmr_q;
    tpr_n      = tpr_q;
    svr_n      = svr_q;
    rsp_v_n    = ack_req;
    rsp_none_n = ack_req;
    rsp_vec_n  = '0;
    rsp_lvl_n  = 1'b0;
    if (eoi_wr && isr_any) isr_n[isr_idx] = 1'b0;
    if (ack_req && en && irr_any) begin
      rsp_none_n = 1'b0;
      if (ack_block) begin
        rsp_vec_n = svr_q[VW-1:0];
      end else begin
        irr_n[irr_idx] = 1'b0;
        isr_n[irr_idx] = 1'b1;
        rsp_vec_n      = irr_idx;
        rsp_lvl_n      = tmr_q[irr_idx];
      end
    end
    if (req_valid) begin
      irr_n[req_vector] = 1'b1;
      tmr_n[req_vector] = req_level;
    end
    if (tpr_wr) tpr_n = tpr_wdata;
    if (svr_wr) svr_n = svr_wdata[VW:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irr_q          <= '0;
      isr_q          <= '0;
      tmr_q          <= '0;
      tpr_q          <= '0;
      svr_q          <= {1'b0, {VW{1'b1}}};
      ack_rsp_valid  <= 1'b0;
      ack_rsp_none   <= 1'b0;
      ack_rsp_vector <= '0;
      ack_rsp_level  <= 1'b0;
    end else begin
      irr_q          <= irr_n;
      isr_q          <= isr_n;
      tmr_q          <= tmr_n;
      tpr_q          <= tpr_n;
      svr_q          <= svr_n;
      ack_rsp_valid  <= rsp_v_n;
      ack_rsp_none   <= rsp_none_n;
      ack_rsp_vector <= rsp_vec_n;
      ack_rsp_level  <= rsp_lvl_n;
    end
  end

  assign spur_rd = svr_q;
endmodule

// File: rtl/vprio_ctrl_chk.sv
module vprio_ctrl_chk #(
  parameter int unsigned NVEC = 256,
  localparam int unsigned VW  = $clog2(NVEC)
) (
  input logic            clk,
  input logic            rst_int_n,
  input logic            ack_req,
  input logic            eoi_wr,
  input logic [VW:0]     svr_q,
  input logic [VW-1:0]   tpr_q,
  input logic [NVEC-1:0] isr_q,
  input logic            irq,
  input logic [VW-1:0]   ppr,
  input logic            ack_rsp_valid,
  input logic            ack_rsp_none
);
  a_r9_irq_low_disabled: assert property (@(posedge clk) disable iff (!rst_int_n)
    !svr_q[VW] |-> !irq);

  a_r9_ack_none_disabled: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack_req && !svr_q[VW]) |=> (ack_rsp_valid && ack_rsp_none));

  a_r5_rsp_follows_ack: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack_req |=> ack_rsp_valid);

  a_r5_no_rsp_without_ack: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ack_req |=> !ack_rsp_valid);

  a_r2_ppr_not_below_tpr: assert property (@(posedge clk) disable iff (!rst_int_n)
    ppr >= tpr_q);

  a_r6_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_int_n)
    (eoi_wr && !ack_req && (isr_q != '0)) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  a_r6_eoi_empty_noop: assert property (@(posedge clk) disable iff (!rst_int_n)
    (eoi_wr && !ack_req && (isr_q == '0)) |=> (isr_q == '0));
endmodule

bind vprio_ctrl vprio_ctrl_chk #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .ack_req(ack_req), .eoi_wr(eoi_wr),
  .svr_q(svr_q), .tpr_q(tpr_q), .isr_q(isr_q), .irq(irq), .ppr(ppr),
  .ack_rsp_valid(ack_rsp_valid), .ack_rsp_none(ack_rsp_none)
);

// File: tb/vprio_ctrl_tb.sv
module vprio_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_level = 1'b0;
  logic        ack_req = 1'b0;
  logic        eoi_wr = 1'b0;
  logic        tpr_wr = 1'b0;
  logic [7:0]  tpr_wdata = '0;
  logic        svr_wr = 1'b0;
  logic [15:0] svr_wdata = '0;
  logic        irq;
  logic [7:0]  ppr;
  logic [8:0]  spur_rd;
  logic        ack_rsp_valid, ack_rsp_none, ack_rsp_level;
  logic [7:0]  ack_rsp_vector;

  vprio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_level(req_level), .ack_req(ack_req), .eoi_wr(eoi_wr), .tpr_wr(tpr_wr),
    .tpr_wdata(tpr_wdata), .svr_wr(svr_wr), .svr_wdata(svr_wdata), .irq(irq),
    .ppr(ppr), .spur_rd(spur_rd), .ack_rsp_valid(ack_rsp_valid),
    .ack_rsp_none(ack_rsp_none), .ack_rsp_vector(ack_rsp_vector),
    .ack_rsp_level(ack_rsp_level)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference state
  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  logic [7:0]   m_tpr = '0;
  logic [8:0]   m_svr = 9'h0FF;

  function automatic int hi(input logic [255:0] v);
    int r = -1;
    for (int i = 0; i < 256; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int m_ppr();
    int tc = m_tpr / 16;
    int h  = hi(m_isr);
    int ic = (h < 0) ? 0 : h / 16;
    return (tc >= ic) ? int'(m_tpr) : ic * 16;
  endfunction

  function automatic bit m_irq();
    int h = hi(m_irr);
    int p = m_ppr();
    if (!m_svr[8] || h < 0) return 1'b0;
    return (p == 0) || (h / 16 > p / 16);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_outs();
    chk(irq == m_irq(), "R3", int'(irq), int'(m_irq()));
    chk(int'(ppr) == m_ppr(), "R2", int'(ppr), m_ppr());
    chk(spur_rd == m_svr, "R8", int'(spur_rd), int'(m_svr));
  endtask

  task automatic do_req(input int v, input bit lvl);
    req_valid = 1'b1; req_vector = 8'(v); req_level = lvl;
    step();
    req_valid = 1'b0;
    m_irr[v] = 1'b1; m_tmr[v] = lvl;
    check_outs();
  endtask

  task automatic do_ack();
    int  h = hi(m_irr);
    bit  e_none = !m_svr[8] || (h < 0);
    bit  e_spur = !e_none && (m_tpr != 0) && (h <= int'(m_tpr));
    int  e_vec  = e_none ? -1 : (e_spur ? int'(m_svr[7:0]) : h);
    bit  e_lvl  = (!e_none && !e_spur) ? m_tmr[h] : 1'b0;
    ack_req = 1'b1;
    step();
    ack_req = 1'b0;
    chk(ack_rsp_valid == 1'b1, "R5", int'(ack_rsp_valid), 1);
    if (e_none) begin
      chk(ack_rsp_none == 1'b1, m_svr[8] ? "R7" : "R9", int'(ack_rsp_none), 1);
    end else begin
      chk(ack_rsp_none == 1'b0, e_spur ? "R4" : "R5", int'(ack_rsp_none), 0);
      chk(int'(ack_rsp_vector) == e_vec, e_spur ? "R4" : "R5", int'(ack_rsp_vector), e_vec);
      if (!e_spur) begin
        chk(ack_rsp_level == e_lvl, "R1", int'(ack_rsp_level), int'(e_lvl));
        m_irr[h] = 1'b0;
        m_isr[h] = 1'b1;
      end
    end
    check_outs();
    step();
    chk(ack_rsp_valid == 1'b0, "R5", int'(ack_rsp_valid), 0);
  endtask

  task automatic do_eoi();
    int h = hi(m_isr);
    eoi_wr = 1'b1;
    step();
    eoi_wr = 1'b0;
    if (h >= 0) m_isr[h] = 1'b0;
    check_outs();
  endtask

  task automatic wr_tpr(input int v);
    tpr_wr = 1'b1; tpr_wdata = 8'(v);
    step();
    tpr_wr = 1'b0;
    m_tpr = 8'(v);
    check_outs();
  endtask

  task automatic wr_svr(input int v);
    svr_wr = 1'b1; svr_wdata = 16'(v);
    step();
    svr_wr = 1'b0;
    m_svr = 9'(v);
    check_outs();
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h1F2E3D4C;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R8: reset state
    chk(spur_rd == 9'h0FF, "R8", int'(spur_rd), 'h0FF);
    chk(ppr == 8'h00, "R8", int'(ppr), 0);
    chk(irq == 1'b0, "R9", int'(irq), 0);
    chk(ack_rsp_valid == 1'b0, "R5", int'(ack_rsp_valid), 0);

    // R9: disabled controller holds the request but does not signal
    do_req(8'h40, 1'b0);
    chk(irq == 1'b0, "R9", int'(irq), 0);
    do_ack();
    // R8: high bits of the write are dropped, enable bit 8 set
    wr_svr(16'hF30F);
    chk(spur_rd == 9'h10F, "R8", int'(spur_rd), 'h10F);
    chk(irq == 1'b1, "R3", int'(irq), 1);
    do_ack();
    do_eoi();

    // R1/R5/R2/R6: every vector on its own
    for (int v = 0; v < 256; v++) begin
      do_req(v, v[0]);
      do_ack();
      chk(int'(ppr) == (v / 16) * 16, "R2", int'(ppr), (v / 16) * 16);
      do_eoi();
    end

    // R7 and R6 on empty state
    do_ack();
    do_eoi();
    chk(ppr == 8'h00, "R6", int'(ppr), 0);

    // R3/R4: task class against pending class, low nibbles equal
    for (int tc = 0; tc < 16; tc++) begin
      for (int pc = 0; pc < 16; pc++) begin
        wr_tpr(tc * 16 + 5);
        do_req(pc * 16 + 5, pc[0]);
        do_ack();
        wr_tpr(0);
        if (m_irr != '0) do_ack();
        do_eoi();
      end
    end

    // mixed operations against the model
    for (int n = 0; n < 6000; n++) begin
      int op;
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      op = int'(seed % 16);
      if (op < 6)       do_req(int'((seed >> 8) & 8'hFF), seed[20]);
      else if (op < 10) do_ack();
      else if (op < 13) do_eoi();
      else if (op < 15) wr_tpr(seed[22] ? 0 : int'((seed >> 12) & 8'hFF));
      else              wr_svr(int'((seed >> 4) & 16'hFFFF) | (seed[27:25] != 3'b000 ? 'h100 : 0));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule